// File: doc/BRIEF.md
# ISA Control Register Access Decoder

This block sits on the host side of a card bus controller and handles the ISA I/O cycles that reach the controller's own control registers. The registers are reached through an index/data pair. A write to the even port loads an index register. An access to the odd port then reads or writes whichever register that index names. A static strap picks how the block recognises its cycles. With internal decoding, the block compares the full 16-bit I/O address against a fixed base of 03E0h/03E1h and also needs the chip select. With external decoding, the active-low chip select alone selects the block and address bit 0 picks the port.

The block keeps a small register file that can map to block RAM. One global control register sits at index 1Eh, and its bit 0 arms power-down mode. The zero-wait-state and ready outputs are open-drain. Each is modelled as a drive-low enable and a drive-high enable. When a pin is released, it is pushed high for exactly one clock and then floats, so a weak pull-up is enough. Read data is driven onto the bus only during a selected read. At all other times the bus is left floating.

Top module: `ctlreg_access`

## Requirements
- R1: After a synchronous reset, the following hold: the index register and the global control register read back 00h, `pwr_down` is 0, `sd_oe` is 0, and all four pin enables are 0.
- R2: When `dec_internal` is 1, a cycle is taken only when `cs_n` is 0 and `sa` is 03E0h or 03E1h. A write to any other address, or a write with `cs_n` high, leaves the index unchanged. A read at any other address never raises `sd_oe`.
- R3: When `dec_internal` is 0, `cs_n` low alone selects the block. Only `sa` bit 0 is decoded, and address bits 15..1 have no effect.
- R4: Address bit 0 = 0 selects the index register (written from `sd_in`, read back on `sd_out`). Address bit 0 = 1 selects the register the index names. Registers keep their written values.
- R5: Index 1Eh is the global control register. One clock after its bit 0 is 1 while `cs_n` is high, `pwr_down` is 1. While `cs_n` is low, `pwr_down` is 0.
- R6: `sd_oe` rises one clock after a selected read strobe (`ior_n` = 0) is first sampled, and carries valid data on `sd_out`. It falls one clock after the strobe is removed.
- R7: During a selected write, `zws_low` is 1 starting one clock after the strobe is sampled and lasting while the strobe is held. On release, `zws_high` is 1 for exactly one clock with `zws_low` at 0, and then both are 0.
- R8: A selected read start holds `rdy_low` at 1 for WAIT_STATES clocks (default 2), starting two clocks after the strobe is first sampled. `rdy_high` then follows for exactly one clock.
- R9: Data-port writes to an index at or above NUM_REGS (default 32), other than 1Eh, are ignored. Data-port reads of such an index return 00h.
- R10: A write commits only on the clock that first samples its strobe low. Changing `sd_in` while the strobe stays low does not alter the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_internal | input | 1 | Strap: 1 = internal address decode, 0 = external chip select only |
| cs_n | input | 1 | Active-low chip select |
| sa | input | ADDR_W (16) | I/O address |
| ior_n | input | 1 | Active-low I/O read strobe |
| iow_n | input | 1 | Active-low I/O write strobe |
| sd_in | input | DW (8) | Write data from the bus |
| sd_out | output | DW (8) | Read data to the bus |
| sd_oe | output | 1 | Read data bus drive enable (0 = high impedance) |
| zws_low | output | 1 | Zero-wait-state pin pulled low |
| zws_high | output | 1 | Zero-wait-state pin briefly driven high on release |
| rdy_low | output | 1 | Ready pin pulled low (wait inserted) |
| rdy_high | output | 1 | Ready pin briefly driven high on release |
| pwr_down | output | 1 | Power-down mode active |

## Verification
The bench targets near-miss addresses such as 03E2h in internal mode. A decoder that compared too few bits would load the index from such a cycle, and the bench catches this by reading the index back. Out-of-range indexes are tested against a known value at index 0. A design that truncated the index would alias 40h onto entry 0 and overwrite it. The bench counts the one-clock push-high after each release cycle by cycle: a pin that pushed for zero clocks, for two clocks, or while still pulled low would fail. Changing write data mid-strobe exposes a design that commits on every low cycle instead of on the first one.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  // Which half of the index/data pair a cycle targets (address bit 0)
  typedef enum logic {
    PORT_INDEX = 1'b0,
    PORT_DATA  = 1'b1
  } port_sel_e;

  // Decoded view of the current bus cycle
  typedef struct packed {
    logic      hit;   // block selected
    port_sel_e port;  // index or data port
    logic      rd;    // read strobe active
    logic      wr;    // write strobe active
  } access_t;

  localparam logic [15:0] DEFAULT_BASE = 16'h03E0;
  localparam logic [7:0]  DEFAULT_GCTL = 8'h1E;

endpackage

// File: rtl/ctlreg_addr_dec.sv
module ctlreg_addr_dec
  import ctlreg_pkg::*;
#(
  parameter int              ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE = ADDR_W'(DEFAULT_BASE)
) (
  input  logic              dec_internal,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] sa,
  input  logic              ior_n,
  input  logic              iow_n,
  output access_t           acc
);

  logic base_match;

  // Full compare of everything above bit 0 against the fixed base pair
  assign base_match = (sa[ADDR_W-1:1] == BASE[ADDR_W-1:1]);

  always_comb begin
    acc.hit  = dec_internal ? (!cs_n && base_match) : !cs_n;
    acc.port = port_sel_e'(sa[0]);
    acc.rd   = !ior_n;
    acc.wr   = !iow_n;
  end

endmodule

// File: rtl/ctlreg_file.sv
module ctlreg_file
  import ctlreg_pkg::*;
#(
  parameter int             DW       = 8,
  parameter int             IW       = 8,
  parameter int             NUM_REGS = 32,
  parameter logic [IW-1:0]  GCTL_IDX = IW'(DEFAULT_GCTL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          index_we,
  input  logic          data_we,
  input  logic [DW-1:0] wdata,
  output logic [IW-1:0] index_q,
  output logic [DW-1:0] data_q,
  output logic [DW-1:0] gctl_q
);

  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [DW-1:0] mem [NUM_REGS];
  logic [DW-1:0] ram_q;
  logic          in_range;
  logic          is_gctl;

  assign in_range = (int'(index_q) < NUM_REGS);
  assign is_gctl  = (index_q == GCTL_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q <= '0;
    end else if (index_we) begin
      index_q <= wdata[IW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gctl_q <= '0;
    end else if (data_we && is_gctl) begin
      gctl_q <= wdata;
    end
  end

  // Plain single-port RAM, no reset, synchronous read: maps to block RAM
  always_ff @(posedge clk) begin
    if (data_we && in_range && !is_gctl) begin
      mem[index_q[AW-1:0]] <= wdata;
    end
    ram_q <= mem[index_q[AW-1:0]];
  end

  always_comb begin
    if (is_gctl) begin
      data_q = gctl_q;
    end else if (in_range) begin
      data_q = ram_q;
    end else begin
      data_q = '0;
    end
  end

  // R1: reset clears the index and the global control register
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (index_q == '0 && gctl_q == '0));

  // R4: the index only moves on an index-port write
  a_r4_index_stable: assert property (@(posedge clk) disable iff (rst)
    !index_we |=> $stable(index_q));

endmodule

// File: rtl/ctlreg_od_pin.sv
module ctlreg_od_pin (
  input  logic clk,
  input  logic rst,
  input  logic hold_req,
  output logic drv_low,
  output logic drv_high
);

  always_ff @(posedge clk) begin
    if (rst) begin
      drv_low  <= 1'b0;
      drv_high <= 1'b0;
    end else begin
      drv_low  <= hold_req;
      drv_high <= drv_low && !hold_req;
    end
  end

  // R7/R8: the push-high lasts a single clock
  a_r7_push_single: assert property (@(posedge clk) disable iff (rst)
    drv_high |=> !drv_high);

  // R7/R8: never drive both ways at once
  a_r7_no_fight: assert property (@(posedge clk) disable iff (rst)
    drv_high |-> !drv_low);

  // R7/R8: every release is followed by the push-high
  a_r7_release_pushes: assert property (@(posedge clk) disable iff (rst)
    $fell(drv_low) |-> drv_high);

endmodule

// File: rtl/ctlreg_access.sv
module ctlreg_access
  import ctlreg_pkg::*;
#(
  parameter int                DW          = 8,
  parameter int                ADDR_W      = 16,
  parameter int                IW          = 8,
  parameter int                NUM_REGS    = 32,
  parameter int                WAIT_STATES = 2,
  parameter logic [ADDR_W-1:0] BASE        = ADDR_W'(DEFAULT_BASE),
  parameter logic [IW-1:0]     GCTL_IDX    = IW'(DEFAULT_GCTL)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dec_internal,
  input  logic              cs_n,
  input  logic [ADDR_W-1:0] sa,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic [DW-1:0]     sd_in,
  output logic [DW-1:0]     sd_out,
  output logic              sd_oe,
  output logic              zws_low,
  output logic              zws_high,
  output logic              rdy_low,
  output logic              rdy_high,
  output logic              pwr_down
);

  localparam int CW    = (WAIT_STATES < 1) ? 1 : $clog2(WAIT_STATES + 1);
  localparam int NPINS = 2;

  access_t         acc;
  logic            ior_q, iow_q;
  logic            rd_start, wr_start;
  logic            index_we, data_we;
  logic [IW-1:0]   index_q;
  logic [DW-1:0]   data_q;
  logic [DW-1:0]   gctl_q;
  logic [CW-1:0]   wait_cnt;
  logic [NPINS-1:0] pin_req, pin_low, pin_high;

  ctlreg_addr_dec #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .dec_internal(dec_internal),
    .cs_n        (cs_n),
    .sa          (sa),
    .ior_n       (ior_n),
    .iow_n       (iow_n),
    .acc         (acc)
  );

  // Strobe history for first-cycle detection
  always_ff @(posedge clk) begin
    if (rst) begin
      ior_q <= 1'b1;
      iow_q <= 1'b1;
    end else begin
      ior_q <= ior_n;
      iow_q <= iow_n;
    end
  end

  assign rd_start = acc.hit && acc.rd && ior_q;
  assign wr_start = acc.hit && acc.wr && iow_q;
  assign index_we = wr_start && (acc.port == PORT_INDEX);
  assign data_we  = wr_start && (acc.port == PORT_DATA);

  ctlreg_file #(
    .DW(DW), .IW(IW), .NUM_REGS(NUM_REGS), .GCTL_IDX(GCTL_IDX)
  ) u_file (
    .clk     (clk),
    .rst     (rst),
    .index_we(index_we),
    .data_we (data_we),
    .wdata   (sd_in),
    .index_q (index_q),
    .data_q  (data_q),
    .gctl_q  (gctl_q)
  );

  // Wait-state counter for the ready pin
  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
    end else if (rd_start) begin
      wait_cnt <= CW'(WAIT_STATES);
    end else if (wait_cnt != '0) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end

  assign pin_req[0] = acc.hit && acc.wr;     // zero-wait-state pin
  assign pin_req[1] = (wait_cnt != '0);      // ready pin

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    ctlreg_od_pin u_pin (
      .clk     (clk),
      .rst     (rst),
      .hold_req(pin_req[g]),
      .drv_low (pin_low[g]),
      .drv_high(pin_high[g])
    );
  end

  assign zws_low  = pin_low[0];
  assign zws_high = pin_high[0];
  assign rdy_low  = pin_low[1];
  assign rdy_high = pin_high[1];

  // Registered read data path
  always_ff @(posedge clk) begin
    if (rst) begin
      sd_oe  <= 1'b0;
      sd_out <= '0;
    end else begin
      sd_oe <= acc.hit && acc.rd;
      if (acc.hit && acc.rd) begin
        sd_out <= (acc.port == PORT_DATA) ? data_q : DW'(index_q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_down <= 1'b0;
    end else begin
      pwr_down <= gctl_q[0] && cs_n;
    end
  end

  // R6: the bus is only driven after a read strobe
  a_r6_oe_after_read: assert property (@(posedge clk) disable iff (rst)
    sd_oe |-> $past(!ior_n));

  // R5: power-down never shows while the block was selected
  a_r5_pd_needs_cs_high: assert property (@(posedge clk) disable iff (rst)
    pwr_down |-> $past(cs_n));

  // R8: wait counter stays within its programmed length
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    int'(wait_cnt) <= WAIT_STATES);

  // R8: a read start always arms the ready wait
  a_r8_read_arms_wait: assert property (@(posedge clk) disable iff (rst)
    (rd_start && WAIT_STATES > 0) |=> (wait_cnt != '0));

endmodule

// File: tb/test_ctlreg_access.sv
module test_ctlreg_access;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        dec_internal = 1'b1;
  logic        cs_n = 1'b1;
  logic [15:0] sa = '0;
  logic        ior_n = 1'b1;
  logic        iow_n = 1'b1;
  logic [7:0]  sd_in = '0;
  logic [7:0]  sd_out;
  logic        sd_oe, zws_low, zws_high, rdy_low, rdy_high, pwr_down;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  logic       oe_prev = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ctlreg_access i_ctlreg_access (
    .clk(clk), .rst(rst), .dec_internal(dec_internal), .cs_n(cs_n), .sa(sa),
    .ior_n(ior_n), .iow_n(iow_n), .sd_in(sd_in), .sd_out(sd_out), .sd_oe(sd_oe),
    .zws_low(zws_low), .zws_high(zws_high), .rdy_low(rdy_low), .rdy_high(rdy_high),
    .pwr_down(pwr_down)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: pops one expectation per read burst on the bus
  always @(negedge clk) begin
    if (!rst && sd_oe && !oe_prev) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected drive", sd_out, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(sd_out == e, "R4/R6 read data", sd_out, e);
      end
    end
    oe_prev = sd_oe;
  end

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    sa = a; sd_in = d; cs_n = 1'b0; iow_n = 1'b0;
    repeat (3) @(negedge clk);
    iow_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  // Driver: pushes the expected value, then runs the read cycle
  task automatic io_read(input logic [15:0] a, input logic [7:0] e, input string req);
    exp_q.push_back(e);
    @(negedge clk);
    sa = a; cs_n = 1'b0; ior_n = 1'b0;
    repeat (3) @(negedge clk);
    ior_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  // Read that must not be taken: the bus must never be driven
  task automatic io_read_miss(input logic [15:0] a, input string req);
    logic seen;
    seen = 1'b0;
    @(negedge clk);
    sa = a; cs_n = 1'b0; ior_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      seen |= sd_oe;
    end
    ior_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!sd_oe && !zws_low && !zws_high && !rdy_low && !rdy_high, "R1 outputs",
        {sd_oe, zws_low, zws_high, rdy_low, rdy_high}, 0);
    chk(!pwr_down, "R1 pwr_down", pwr_down, 0);
    io_read(16'h03E0, 8'h00, "R1 index reset");
    io_write(16'h03E0, 8'h1E);
    io_read(16'h03E1, 8'h00, "R1 gctl reset");

    // R4 index/data pair
    io_write(16'h03E0, 8'h00); io_write(16'h03E1, 8'h99);
    io_write(16'h03E0, 8'h05); io_write(16'h03E1, 8'h3C);
    io_write(16'h03E0, 8'h06); io_write(16'h03E1, 8'hA1);
    io_write(16'h03E0, 8'h05);
    io_read(16'h03E1, 8'h3C, "R4 data 05");
    io_read(16'h03E0, 8'h05, "R4 index readback");
    io_write(16'h03E0, 8'h06);
    io_read(16'h03E1, 8'hA1, "R4 data 06");

    // R2 internal decode rejects near misses
    io_write(16'h03E2, 8'h77);
    io_write(16'h13E0, 8'h77);
    io_read(16'h03E0, 8'h06, "R2 index unchanged by 03E2/13E0");
    io_read_miss(16'h03E4, "R2 no drive at 03E4");
    io_read_miss(16'h1234, "R2 no drive at 1234");
    @(negedge clk); sa = 16'h03E0; sd_in = 8'h11; iow_n = 1'b0;  // cs_n high
    repeat (3) @(negedge clk); iow_n = 1'b1; repeat (2) @(negedge clk);
    io_read(16'h03E0, 8'h06, "R2 cs_n high ignored");

    // R9 out-of-range index
    io_write(16'h03E0, 8'h40); io_write(16'h03E1, 8'h5A);
    io_read(16'h03E1, 8'h00, "R9 out of range reads zero");
    io_write(16'h03E0, 8'h00);
    io_read(16'h03E1, 8'h99, "R9 entry 0 not aliased");

    // R10 single commit per strobe
    io_write(16'h03E0, 8'h08);
    @(negedge clk); sa = 16'h03E1; sd_in = 8'h11; cs_n = 1'b0; iow_n = 1'b0;
    repeat (2) @(negedge clk); sd_in = 8'h22;
    repeat (2) @(negedge clk); iow_n = 1'b1; cs_n = 1'b1;
    repeat (2) @(negedge clk);
    io_read(16'h03E1, 8'h11, "R10 first-cycle commit");

    // R5 power-down
    io_write(16'h03E0, 8'h1E); io_write(16'h03E1, 8'h01);
    @(negedge clk);
    chk(pwr_down, "R5 pwr_down set with cs_n high", pwr_down, 1);
    @(negedge clk); cs_n = 1'b0; sa = 16'h1000;
    @(negedge clk); @(negedge clk);
    chk(!pwr_down, "R5 pwr_down off while cs_n low", pwr_down, 0);
    cs_n = 1'b1; repeat (2) @(negedge clk);
    io_read(16'h03E1, 8'h01, "R5 gctl readback");
    io_write(16'h03E1, 8'h00);
    @(negedge clk);
    chk(!pwr_down, "R5 pwr_down cleared", pwr_down, 0);

    // R7 zero-wait-state pin timing
    @(negedge clk); sa = 16'h03E0; sd_in = 8'h09; cs_n = 1'b0; iow_n = 1'b0;
    @(negedge clk);
    chk(zws_low, "R7 low one clock after strobe", zws_low, 1);
    @(negedge clk); @(negedge clk);
    chk(zws_low && !zws_high, "R7 held low", {zws_low, zws_high}, 2);
    iow_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    chk(!zws_low && zws_high, "R7 push high on release", {zws_low, zws_high}, 1);
    @(negedge clk);
    chk(!zws_low && !zws_high, "R7 float after one clock", {zws_low, zws_high}, 0);

    // R8 ready pin timing, R6 enable timing
    exp_q.push_back(8'h09);
    @(negedge clk); sa = 16'h03E0; cs_n = 1'b0; ior_n = 1'b0;
    @(negedge clk);
    chk(!rdy_low && sd_oe, "R8/R6 first clock", {rdy_low, sd_oe}, 1);
    @(negedge clk);
    chk(rdy_low, "R8 wait 1", rdy_low, 1);
    @(negedge clk);
    chk(rdy_low && !rdy_high, "R8 wait 2", {rdy_low, rdy_high}, 2);
    ior_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    chk(!rdy_low && rdy_high, "R8 push high", {rdy_low, rdy_high}, 1);
    chk(!sd_oe, "R6 release after strobe", sd_oe, 0);
    @(negedge clk);
    chk(!rdy_low && !rdy_high, "R8 float", {rdy_low, rdy_high}, 0);

    // R3 external decode: upper address bits ignored
    dec_internal = 1'b0;
    io_write(16'h1234, 8'h07);
    io_write(16'hABCD, 8'h42);
    io_read(16'h0001, 8'h42, "R3 external data port");
    io_read(16'h5550, 8'h07, "R3 external index port");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule